// File: doc/BRIEF.md
# Tick-Driven Decrementer with Auto-Reload

This block is a down-counter that advances on a time-base tick enable and raises an interrupt request when it runs out. Software loads the count directly. A separate reload register can restart the count on its own each time it expires. A control word holds an interrupt enable and an auto-reload enable. A status word holds a sticky expiry flag, which software clears by writing a one to it.

A tick is a single-cycle enable pulse from an external time base. On each tick the count drops by one. When a tick takes the count from one to zero, the block records an expiry. After that, the count either stays at zero or restarts from the reload register. A reload value of zero is never loaded. This keeps a counter resting at zero from raising a fresh expiry on every tick. The interrupt line is the expiry flag masked by the interrupt enable.

All interfaces are plain register write strobes and level outputs. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `dtick_dec`

## Requirements
- R1: After reset the count, the reload value, the control word and the status word are all zero, and `irq_o` is low.
- R2: The count changes only on a cycle with `tick` high or `cnt_we` high. On a tick with a count above one, the count drops by exactly one.
- R3: An expiry is a tick that takes the count from 1 to 0. It sets status bit 27 on the next edge. A tick with the count already at zero, or a software write of zero, does not set bit 27.
- R4: With control bit 22 clear, an expiry leaves the count at zero. Later ticks keep it at zero and it never wraps.
- R5: With control bit 22 set and a nonzero reload value, an expiry loads the count with the reload value instead of zero.
- R6: With control bit 22 set and a reload value of zero, an expiry leaves the count at zero. Later ticks raise no further expiry.
- R7: A write to the count (`cnt_we`) takes priority over a tick in the same cycle. The written value is loaded, and no decrement, reload or expiry happens in that cycle.
- R8: Status bit 27 clears only when `sts_clr_we` is high and bit 27 of `sts_clr_wdata` is 1. Writing 0 to that bit leaves it unchanged. If an expiry and a clear fall in the same cycle, the bit stays set.
- R9: `irq_o` is high exactly when status bit 27 and control bit 26 (interrupt enable) are both set.
- R10: The control word keeps only bit 26 and bit 22. All other control bits read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base tick enable, one cycle per tick |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 32 | Value to load into the count |
| rld_we | input | 1 | Reload register write strobe |
| rld_wdata | input | 32 | Value for the reload register |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word (bit 26 interrupt enable, bit 22 auto-reload enable) |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_wdata | input | 32 | Write-one-to-clear mask (bit 27 expiry flag) |
| cnt_o | output | 32 | Current count |
| rld_o | output | 32 | Current reload value |
| ctl_o | output | 32 | Current control word |
| sts_o | output | 32 | Current status word |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume every input is known after reset and changes only between clock edges. They place no limit on how ticks and writes are spaced: a tick may land in the same cycle as any write. The stimulus drives every input on the falling edge and keeps it for one full cycle. It deliberately combines a tick with a count write, and an expiry with a status clear, so that the priority rules are covered.

// File: rtl/dtick_pkg.sv
package dtick_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned FLAG_B  = 27;
  localparam int unsigned IEN_B   = 26;
  localparam int unsigned AREL_B  = 22;
  localparam logic [REG_W-1:0] CTL_KEEP = (REG_W'(1) << IEN_B) | (REG_W'(1) << AREL_B);
endpackage

// File: rtl/dtick_counter.sv
module dtick_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         arel_en,
  input  logic [W-1:0] arel_val,
  output logic [W-1:0] count,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  logic         at_one;
  logic         at_zero;
  logic         use_reload;
  logic [W-1:0] nxt;

  assign at_one     = (count == ONE);
  assign at_zero    = (count == '0);
  // Expiry only on a real 1 -> 0 transition that software did not preempt.
  assign expire     = tick && !wr_en && at_one;
  assign use_reload = arel_en && (arel_val != '0);

  always_comb begin
    nxt = count;
    if (wr_en) begin
      nxt = wr_val;
    end else if (tick && !at_zero) begin
      if (at_one) nxt = use_reload ? arel_val : '0;
      else        nxt = count - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end
endmodule

// File: rtl/dtick_status.sv
module dtick_status #(
  parameter int unsigned RW  = 32,
  parameter int unsigned BIT = 27
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic          clr_we,
  input  logic [RW-1:0] clr_mask,
  output logic          flag
);
  logic clr_hit;
  assign clr_hit = clr_we && clr_mask[BIT];

  // A new event outranks a simultaneous acknowledge so none is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_i)   flag <= 1'b1;
    else if (clr_hit) flag <= 1'b0;
  end
endmodule

// File: rtl/dtick_ctrl.sv
module dtick_ctrl #(
  parameter int unsigned       RW   = 32,
  parameter logic [RW-1:0]     KEEP = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] wdata,
  output logic [RW-1:0] word
);
  for (genvar b = 0; b < RW; b++) begin : g_bit
    if (KEEP[b]) begin : g_kept
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  word[b] <= 1'b0;
        else if (we) word[b] <= wdata[b];
      end
    end else begin : g_tied
      assign word[b] = 1'b0;
    end
  end
endmodule

// File: rtl/dtick_dec.sv
module dtick_dec
  import dtick_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_we,
  input  logic [CW-1:0]    cnt_wdata,
  input  logic             rld_we,
  input  logic [CW-1:0]    rld_wdata,
  input  logic             ctl_we,
  input  logic [REG_W-1:0] ctl_wdata,
  input  logic             sts_clr_we,
  input  logic [REG_W-1:0] sts_clr_wdata,
  output logic [CW-1:0]    cnt_o,
  output logic [CW-1:0]    rld_o,
  output logic [REG_W-1:0] ctl_o,
  output logic [REG_W-1:0] sts_o,
  output logic             irq_o
);
  logic [CW-1:0]    rld_q;
  logic [REG_W-1:0] ctl_q;
  logic             expire;
  logic             flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rld_q <= '0;
    else if (rld_we) rld_q <= rld_wdata;
  end

  dtick_ctrl #(.RW(REG_W), .KEEP(CTL_KEEP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata), .word(ctl_q)
  );

  dtick_counter #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_en(cnt_we), .wr_val(cnt_wdata),
    .arel_en(ctl_q[AREL_B]), .arel_val(rld_q),
    .count(cnt_o), .expire(expire)
  );

  dtick_status #(.RW(REG_W), .BIT(FLAG_B)) u_sts (
    .clk(clk), .rst_n(rst_n), .set_i(expire),
    .clr_we(sts_clr_we), .clr_mask(sts_clr_wdata), .flag(flag)
  );

  always_comb begin
    sts_o         = '0;
    sts_o[FLAG_B] = flag;
  end

  assign rld_o = rld_q;
  assign ctl_o = ctl_q;
  assign irq_o = flag && ctl_q[IEN_B];
endmodule

// File: rtl/dtick_checker.sv
module dtick_checker
  import dtick_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cnt_we,
  input logic [CW-1:0]    cnt_wdata,
  input logic             sts_clr_we,
  input logic [REG_W-1:0] sts_clr_wdata,
  input logic [CW-1:0]    cnt_o,
  input logic [CW-1:0]    rld_o,
  input logic [REG_W-1:0] ctl_o,
  input logic [REG_W-1:0] sts_o
);
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> $stable(cnt_o));

  p_step_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && cnt_o > CW'(1)) |=> (cnt_o == $past(cnt_o) - CW'(1)));

  p_flag_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_o[FLAG_B]) |-> $past(tick && !cnt_we && cnt_o == CW'(1)));

  p_rest_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == '0 && !cnt_we) |=> (cnt_o == '0));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && cnt_o == CW'(1) && ctl_o[AREL_B] && rld_o != '0)
      |=> (cnt_o == $past(rld_o)));

  p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_o == $past(cnt_wdata)));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_o[FLAG_B] && !(sts_clr_we && sts_clr_wdata[FLAG_B])) |=> sts_o[FLAG_B]);
endmodule

bind dtick_dec dtick_checker #(.CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
  .sts_clr_we(sts_clr_we), .sts_clr_wdata(sts_clr_wdata),
  .cnt_o(cnt_o), .rld_o(rld_o), .ctl_o(ctl_o), .sts_o(sts_o)
);

// File: tb/test_dtick_dec.sv
module test_dtick_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        cnt_we = 1'b0;
  logic [31:0] cnt_wdata = '0;
  logic        rld_we = 1'b0;
  logic [31:0] rld_wdata = '0;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic        sts_clr_we = 1'b0;
  logic [31:0] sts_clr_wdata = '0;
  logic [31:0] cnt_o, rld_o, ctl_o, sts_o;
  logic        irq_o;

  localparam logic [31:0] IEN  = 32'h0400_0000; // bit 26
  localparam logic [31:0] AREL = 32'h0040_0000; // bit 22
  localparam logic [31:0] FLAG = 32'h0800_0000; // bit 27

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  dtick_dec i_dtick_dec (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .rld_we(rld_we), .rld_wdata(rld_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .sts_clr_we(sts_clr_we), .sts_clr_wdata(sts_clr_wdata),
    .cnt_o(cnt_o), .rld_o(rld_o), .ctl_o(ctl_o), .sts_o(sts_o), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic wr_cnt(logic [31:0] v);
    cnt_we = 1'b1; cnt_wdata = v; @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic wr_rld(logic [31:0] v);
    rld_we = 1'b1; rld_wdata = v; @(negedge clk); rld_we = 1'b0;
  endtask

  task automatic wr_ctl(logic [31:0] v);
    ctl_we = 1'b1; ctl_wdata = v; @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic clr_sts(logic [31:0] m);
    sts_clr_we = 1'b1; sts_clr_wdata = m; @(negedge clk); sts_clr_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 count", cnt_o, 0);
    chk("R1 reload", rld_o, 0);
    chk("R1 control", ctl_o, 0);
    chk("R1 status", sts_o, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_count_down;
    wr_cnt(5);
    chk("R2 loaded", cnt_o, 5);
    cyc(3);
    chk("R2 no tick holds", cnt_o, 5);
    ticks(2);
    chk("R2 two ticks", cnt_o, 3);
  endtask

  task automatic t_expire_stop;
    wr_ctl(IEN);
    ticks(2);
    chk("R3 before expiry status", sts_o, 0);
    chk("R9 before expiry irq", {31'b0, irq_o}, 0);
    ticks(1);
    chk("R3 expiry count", cnt_o, 0);
    chk("R3 expiry status", sts_o, FLAG);
    chk("R9 irq enabled", {31'b0, irq_o}, 1);
    ticks(3);
    chk("R4 stays zero", cnt_o, 0);
    clr_sts(32'hF7FF_FFFF);
    chk("R8 write zero keeps", sts_o, FLAG);
    clr_sts(FLAG);
    chk("R8 w1c clears", sts_o, 0);
    chk("R9 irq drops", {31'b0, irq_o}, 0);
    ticks(3);
    chk("R3 no retrigger at zero", sts_o, 0);
    wr_cnt(0);
    chk("R3 writing zero no expiry", sts_o, 0);
  endtask

  task automatic t_irq_mask;
    wr_ctl(0);
    wr_cnt(1);
    ticks(1);
    chk("R3 status masked case", sts_o, FLAG);
    chk("R9 irq masked", {31'b0, irq_o}, 0);
    wr_ctl(IEN);
    chk("R9 irq after enable", {31'b0, irq_o}, 1);
    clr_sts(FLAG);
  endtask

  task automatic t_reload;
    wr_ctl(IEN | AREL);
    wr_rld(4);
    wr_cnt(2);
    ticks(2);
    chk("R5 reloaded", cnt_o, 4);
    chk("R5 status", sts_o, FLAG);
    clr_sts(FLAG);
    ticks(3);
    chk("R5 counts again", cnt_o, 1);
    ticks(1);
    chk("R5 second reload", cnt_o, 4);
    chk("R5 second expiry", sts_o, FLAG);
    clr_sts(FLAG);
  endtask

  task automatic t_zero_reload;
    wr_ctl(AREL);
    wr_rld(0);
    wr_cnt(1);
    ticks(1);
    chk("R6 stays zero", cnt_o, 0);
    chk("R6 one expiry", sts_o, FLAG);
    clr_sts(FLAG);
    ticks(4);
    chk("R6 count", cnt_o, 0);
    chk("R6 no retrigger", sts_o, 0);
  endtask

  task automatic t_write_priority;
    wr_ctl(AREL);
    wr_rld(9);
    wr_cnt(1);
    tick = 1'b1; cnt_we = 1'b1; cnt_wdata = 7;
    @(negedge clk);
    tick = 1'b0; cnt_we = 1'b0;
    chk("R7 write beats expiry", cnt_o, 7);
    chk("R7 no expiry", sts_o, 0);
    tick = 1'b1; cnt_we = 1'b1; cnt_wdata = 32'hFFFF_FFF0;
    @(negedge clk);
    tick = 1'b0; cnt_we = 1'b0;
    chk("R7 write beats decrement", cnt_o, 32'hFFFF_FFF0);
  endtask

  task automatic t_set_beats_clear;
    wr_ctl(0);
    wr_cnt(1);
    tick = 1'b1; sts_clr_we = 1'b1; sts_clr_wdata = FLAG;
    @(negedge clk);
    tick = 1'b0; sts_clr_we = 1'b0;
    chk("R8 set wins over clear", sts_o, FLAG);
    clr_sts(32'hFFFF_FFFF);
    chk("R8 all ones clears", sts_o, 0);
  endtask

  task automatic t_ctl_bits;
    wr_ctl(32'hFFFF_FFFF);
    chk("R10 kept bits", ctl_o, IEN | AREL);
    wr_ctl(0);
    chk("R10 cleared", ctl_o, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    cyc(2);
    t_reset;
    rst_n = 1'b1;
    cyc(1);
    t_count_down;
    t_expire_stop;
    t_irq_mask;
    t_reload;
    t_zero_reload;
    t_write_priority;
    t_set_beats_clear;
    t_ctl_bits;
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run;
  end
endmodule